// File: doc/BRIEF.md
# SPI Pin Direct-Access Arbiter

This block lets host software take bit-level control of the four wires of a serial EEPROM (clock, active-low select, data out to the device, data back from the device). Those wires are normally driven by an internal autonomous EEPROM engine. Software sets a request bit in a 16-bit control register. Once the engine is between transactions, the block grants access. From then on, three register bits drive the clock, select and data-out pins directly, and a fourth bit shows the live data-in pin.

While the request or the grant is set, the engine is told to hold off. Without a grant, the pins follow the engine. The same register also reports whether an EEPROM is fitted and carries its 4-bit size code. Code 7 stands for 16 KB and code 8 for 32 KB; other codes are unsupported and are passed through unchanged.

If software leaves the pins untouched for too long, an inactivity counter withdraws the request and the grant by itself. The timeout is set by the `IDLE_LIMIT` parameter, in clock cycles.

Top module: `spi_pin_arbiter`

## Requirements
- R1: While the grant is set, `sck` equals register bit 0, `cs_n` equals bit 1 and `si` equals bit 2, in the same cycle the bits are stored. Writing 1 to bit 1 deselects the device.
- R2: Bit 7 (grant, read-only) becomes 1 on the clock edge after one where the request bit (bit 6) was already 1, stays 1 after that edge, and `eng_idle` was 1. Once set, it stays set while the request stays set, whatever `eng_idle` does. It clears on the same edge as the request.
- R3: While the grant is clear, `sck`, `cs_n` and `si` equal `eng_sck`, `eng_cs_n` and `eng_si`.
- R4: `eng_hold` is 1 whenever the request bit or the grant bit is 1, and 0 otherwise.
- R5: While the request is set, a count of cycles restarts on every write that changes any of bits 2:0. After `IDLE_LIMIT` cycles with no such change, counted from the edge that set the request, the request and the grant both clear. Writes that leave bits 2:0 unchanged do not restart the count. The expiry takes priority over a write of 1 to the request bit in the same cycle.
- R6: Bit 3 reads the live value of `so`. Writes to it are ignored.
- R7: Bit 8 reads `ee_present`, and bits 14:11 read `ee_size` (7 = 16 KB, 8 = 32 KB, other codes unsupported and passed through unchanged).
- R8: Bits 4, 5, 9, 10 and 15 read 0. Writes to them and to the read-only bits have no effect.
- R9: After reset, bit 1 (select) is 1, and bits 0, 2, the request and the grant are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| eng_idle | input | 1 | Engine is between transactions |
| eng_sck | input | 1 | Engine clock drive |
| eng_cs_n | input | 1 | Engine select drive, active low |
| eng_si | input | 1 | Engine data drive to the device |
| eng_hold | output | 1 | Engine must not start a transaction |
| ee_present | input | 1 | EEPROM fitted |
| ee_size | input | 4 | EEPROM size code |
| sck | output | 1 | Clock pin |
| cs_n | output | 1 | Select pin, active low |
| si | output | 1 | Data pin toward the device |
| so | input | 1 | Data pin from the device |

## Verification
The assertions check four rules on every cycle:
- the pin mux, in both its granted and engine-owned states;
- that a grant never exists without a request;
- that a grant only rises after the request was held while the engine was idle;
- that the engine is held off whenever a grant exists.

The live `so` read-back is also checked on every cycle. The timeout length cannot be shown by these rules, and neither can the difference between value-changing and value-preserving writes, the priority of expiry over a simultaneous write, or the status pass-through for each size code. The bench shows these through scenarios compared against its reference model on every clock.

// File: rtl/spi_pin_arbiter.sv
module spi_pin_arbiter #(
  parameter int IDLE_LIMIT = 250_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        eng_idle,
  input  logic        eng_sck,
  input  logic        eng_cs_n,
  input  logic        eng_si,
  output logic        eng_hold,
  input  logic        ee_present,
  input  logic [3:0]  ee_size,
  output logic        sck,
  output logic        cs_n,
  output logic        si,
  input  logic        so
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_LIMIT - 1);

  logic          sck_q, cs_q, si_q, req_q, gnt_q;
  logic [CW-1:0] idle_q;
  logic          pin_chg, expire, req_d;

  assign pin_chg = wr_en && (wr_data[2:0] != {si_q, cs_q, sck_q});
  assign expire  = req_q && !pin_chg && (idle_q == LAST);
  assign req_d   = expire ? 1'b0 : (wr_en ? wr_data[6] : req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      si_q   <= 1'b0;
      req_q  <= 1'b0;
      gnt_q  <= 1'b0;
      idle_q <= '0;
    end else begin
      if (wr_en) begin
        sck_q <= wr_data[0];
        cs_q  <= wr_data[1];
        si_q  <= wr_data[2];
      end
      req_q <= req_d;
      gnt_q <= req_q && req_d && (gnt_q || eng_idle);
      if (!req_q || pin_chg || expire) idle_q <= '0;
      else                             idle_q <= idle_q + 1'b1;
    end
  end

  assign sck      = gnt_q ? sck_q : eng_sck;
  assign cs_n     = gnt_q ? cs_q  : eng_cs_n;
  assign si       = gnt_q ? si_q  : eng_si;
  assign eng_hold = req_q | gnt_q;
  assign rd_data  = {1'b0, ee_size, 2'b00, ee_present, gnt_q, req_q,
                     2'b00, so, si_q, cs_q, sck_q};
endmodule

// File: rtl/spi_pin_arbiter_chk.sv
module spi_pin_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_data,
  input logic        eng_idle,
  input logic        eng_sck,
  input logic        eng_cs_n,
  input logic        eng_si,
  input logic        eng_hold,
  input logic        sck,
  input logic        cs_n,
  input logic        si,
  input logic        so
);
  assert_pins_sw_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> (sck == rd_data[0] && cs_n == rd_data[1] && si == rd_data[2]));
  assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> rd_data[6]);
  assert_gnt_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[7]) |-> ($past(rd_data[6]) && $past(eng_idle)));
  assert_pins_eng_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> (sck == eng_sck && cs_n == eng_cs_n && si == eng_si));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> eng_hold);
  assert_so_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] == so);
endmodule

bind spi_pin_arbiter spi_pin_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .eng_idle(eng_idle),
  .eng_sck(eng_sck), .eng_cs_n(eng_cs_n), .eng_si(eng_si),
  .eng_hold(eng_hold), .sck(sck), .cs_n(cs_n), .si(si), .so(so)
);

// File: tb/spi_pin_arbiter_tb.sv
module spi_pin_arbiter_tb;
  localparam int LIM = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        eng_idle = 1'b0, eng_sck = 1'b0, eng_cs_n = 1'b1, eng_si = 1'b0;
  logic        eng_hold, sck, cs_n, si;
  logic        ee_present = 1'b1;
  logic [3:0]  ee_size = 4'd7;
  logic        so = 1'b0;

  int checks = 0;
  int failures = 0;
  bit running = 0;

  logic m_sck = 0, m_cs = 1, m_si = 0, m_req = 0, m_gnt = 0;
  int   m_idle = 0;

  always #5 clk = ~clk;

  spi_pin_arbiter #(.IDLE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .eng_idle(eng_idle), .eng_sck(eng_sck), .eng_cs_n(eng_cs_n), .eng_si(eng_si),
    .eng_hold(eng_hold), .ee_present(ee_present), .ee_size(ee_size),
    .sck(sck), .cs_n(cs_n), .si(si), .so(so)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: request/grant/timer rules as stated in the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sck <= 0; m_cs <= 1; m_si <= 0; m_req <= 0; m_gnt <= 0; m_idle <= 0;
    end else begin
      bit chg, exp_now, nreq;
      chg = wr_en && (wr_data[0] != m_sck || wr_data[1] != m_cs || wr_data[2] != m_si);
      exp_now = m_req && !chg && (m_idle + 1 >= LIM);
      if (exp_now) nreq = 0;
      else if (wr_en) nreq = wr_data[6];
      else nreq = m_req;
      m_gnt <= m_req && nreq && (m_gnt || eng_idle);
      m_req <= nreq;
      m_idle <= (!m_req || chg || exp_now) ? 0 : m_idle + 1;
      if (wr_en) begin m_sck <= wr_data[0]; m_cs <= wr_data[1]; m_si <= wr_data[2]; end
    end
  end

  always @(negedge clk) if (running) begin
    logic e_sck, e_cs, e_si;
    e_sck = m_gnt ? m_sck : eng_sck;
    e_cs  = m_gnt ? m_cs  : eng_cs_n;
    e_si  = m_gnt ? m_si  : eng_si;
    chk(rd_data[2:0] == {m_si, m_cs, m_sck}, "R1 stored pin bits", rd_data[2:0], {m_si, m_cs, m_sck});
    chk({cs_n, sck, si} == {e_cs, e_sck, e_si}, m_gnt ? "R1 pins granted" : "R3 pins engine",
        {cs_n, sck, si}, {e_cs, e_sck, e_si});
    chk(rd_data[7] == m_gnt, "R2 grant bit", rd_data[7], m_gnt);
    chk(eng_hold == (m_req | m_gnt), "R4 engine hold", eng_hold, m_req | m_gnt);
    chk(rd_data[6] == m_req, "R5 request bit", rd_data[6], m_req);
    chk(rd_data[3] == so, "R6 so readback", rd_data[3], so);
    chk(rd_data[8] == ee_present && rd_data[14:11] == ee_size, "R7 status",
        {rd_data[14:11], rd_data[8]}, {ee_size, ee_present});
    chk({rd_data[15], rd_data[10:9], rd_data[5:4]} == 5'b0, "R8 reserved zero",
        {rd_data[15], rd_data[10:9], rd_data[5:4]}, 0);
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr_en = 0;
      eng_sck = $urandom; eng_si = $urandom; so = $urandom;
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); #1;
    wr_en = 1; wr_data = v;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #12;
    chk(rd_data[7:0] == 8'h02 && cs_n == eng_cs_n, "R9 reset values", rd_data[7:0], 8'h02);
    rst_n = 1;
    running = 1;
    // engine owns the pins, no request
    eng_idle = 0;
    for (int i = 0; i < 6; i++) begin tick(); eng_cs_n = i[0]; end
    // software pin bits stored but do not reach pins; status codes
    wr(16'h0005);
    ee_size = 4'd8; tick(2);
    ee_size = 4'd3; ee_present = 0; tick(2);
    ee_size = 4'd7; ee_present = 1;
    // read-only and reserved bits ignored
    wr(16'hFFBA); tick(2);
    chk(rd_data[7] == 1'b0, "R8 grant not writable", rd_data[7], 0);
    wr(16'h0002);
    // request while engine busy: no grant
    wr(16'h0042); tick(3);
    chk(rd_data[7] == 1'b0, "R2 no grant while engine busy", rd_data[7], 0);
    eng_idle = 1; tick(2);
    chk(rd_data[7] == 1'b1, "R2 grant once idle", rd_data[7], 1);
    eng_idle = 0; tick(2);
    // bit-bang a byte: activity keeps request alive
    for (int b = 7; b >= 0; b--) begin
      logic d;
      d = b[0] ^ b[1];
      wr({9'h0, 1'b1, 3'b0, d, 1'b0, 1'b0});
      wr({9'h0, 1'b1, 3'b0, d, 1'b0, 1'b1});
      tick(2);
    end
    chk(rd_data[6] == 1'b1, "R5 activity keeps request", rd_data[6], 1);
    // same-value writes do not reload; let it expire
    for (int i = 0; i < LIM; i++) wr(16'h0043);
    tick(LIM);
    chk(rd_data[7:6] == 2'b00, "R5 expiry clears request and grant", rd_data[7:6], 0);
    // software release by writing request low
    eng_idle = 1;
    wr(16'h0046); tick(3);
    wr(16'h0006); tick(3);
    chk(rd_data[7:6] == 2'b00, "R2 release clears grant", rd_data[7:6], 0);
    // full idle expiry with no writes at all
    wr(16'h0042); tick(LIM + 4);
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule